// File: doc/BRIEF.md
# ADC Conversion Sequencer with Shadowed Selection

This block sequences a successive-approximation converter from the system clock. Two single-cycle tick inputs mark the rising and falling half-periods of the slower converter clock, and every timing rule below is counted in those ticks. Software-side writes arrive as plain strobes. They can set the channel/reference selection, and they can set the control bits: enable, start, free-running, and completion-flag clear.

The selection written by software is kept in a shadow register that can be read back at any time. A second, active copy drives the converter. The active copy follows the shadow while the block is idle and again in the final cycle of a conversion, and it is frozen during acquisition. A conversion begins on the first rising tick after the start write. The first conversion after enable runs 25 converter cycles and later ones run 13. A sample-and-hold strobe fires on a falling tick, and at completion the 10-bit value on the data input is captured as a high and a low byte.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A selection write updates `sel_shadow` on the clock edge of the write, whether or not a conversion is running.
- R2: While no conversion is running, `sel_active` takes the value of `sel_shadow` on every clock edge at which `tick_rise` is high.
- R3: From the rising tick that starts a conversion up to, but not including, its completion tick, `sel_active` does not change.
- R4: On the rising tick that completes a conversion, `sel_active` loads the current `sel_shadow` value.
- R5: A start write with enable set makes `start_pend` read 1 from the next clock. `busy` rises on the following `tick_rise` edge. `start_pend` and `busy` both return to 0 at completion.
- R6: The first conversion after enable completes on the 25th rising tick counted from and including its start tick. Every later conversion completes on the 13th.
- R7: `sh_strobe` pulses for one clock after the falling tick of converter cycle 2 of a normal conversion, and after that of cycle 14 of an extended conversion. Cycle 1 begins at the start tick.
- R8: `done_flag` is set at completion and cleared by a control write with the clear bit at 1. A completion in the same clock as the clear wins.
- R9: At completion, the 10-bit `conv_value` is latched. `res_lo` holds bits 7:0, and `res_hi` holds bits 9:8 in its bits 1:0 with zeros above.
- R10: With free-running set, each completion is followed by a new conversion that starts on the next rising tick, with no new start write.
- R11: A start write is ignored while a conversion is pending or running, and also when the same write clears enable.
- R12: A control write that clears enable aborts any pending or running conversion without setting `done_flag`. The next conversion after re-enable is an extended one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_rise | input | 1 | One-clock marker of a converter-clock rising half-period |
| tick_fall | input | 1 | One-clock marker of a converter-clock falling half-period |
| sel_we | input | 1 | Selection write strobe |
| sel_wdata | input | SEL_W (6) | Selection write data, reference in the upper REF_W bits, channel below |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable bit of the control write |
| ctrl_start | input | 1 | Start bit of the control write |
| ctrl_free | input | 1 | Free-running bit of the control write |
| ctrl_clr | input | 1 | Write 1 to clear the completion flag |
| conv_value | input | RES_W (10) | Digital value from the converter |
| sel_shadow | output | SEL_W (6) | Shadow selection readback |
| sel_active | output | SEL_W (6) | Selection driving the converter |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| busy | output | 1 | Conversion running |
| start_pend | output | 1 | Start readback: pending or running |
| done_flag | output | 1 | Completion flag |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
The hardest case to reach from the ports is a change to the shadow selection in the middle of a conversion. The bench must show that the active copy stays frozen and then takes the new value in the completion cycle itself, not one cycle later. The bench writes a new selection a few rising ticks into the extended first conversion and watches `sel_active` every clock until `done_flag` rises. It then checks the value in that same clock. The abort-then-re-enable path is also driven to show that the long conversion comes back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Completion happens on the rising tick that enters the last cycle,
  // i.e. when the running cycle index equals total length minus one.
  function automatic int unsigned last_index(input logic ext,
                                             input int unsigned norm_len,
                                             input int unsigned ext_len);
    return ext ? (ext_len - 1) : (norm_len - 1);
  endfunction

  // Cycle whose falling half-period carries the sample-and-hold strobe.
  function automatic int unsigned sh_index(input logic ext,
                                           input int unsigned sh_norm,
                                           input int unsigned sh_ext);
    return ext ? sh_ext : sh_norm;
  endfunction

  // Right-aligned split of a converter value into a byte pair.
  function automatic logic [15:0] split_bytes(input logic [15:0] value);
    return value;
  endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned NORM_CYC = 13,
  parameter int unsigned EXT_CYC  = 25,
  parameter int unsigned SH_NORM  = 2,
  parameter int unsigned SH_EXT   = 14,
  parameter int unsigned CNT_W    = $clog2(EXT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_rise,
  input  logic tick_fall,
  input  logic ctrl_we,
  input  logic ctrl_en,
  input  logic ctrl_start,
  input  logic ctrl_free,
  output logic busy_q,
  output logic pending_q,
  output logic ev_start,
  output logic ev_done,
  output logic sh_strobe
);

  logic             en_q;
  logic             free_q;
  logic             first_q;
  logic             ext_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] sh_cnt;
  logic             wr_abort;
  logic             wr_go;
  logic             sh_hit;

  assign last_cnt = CNT_W'(last_index(ext_q, NORM_CYC, EXT_CYC));
  assign sh_cnt   = CNT_W'(sh_index(ext_q, SH_NORM, SH_EXT));

  assign wr_abort = ctrl_we & ~ctrl_en;
  assign wr_go    = ctrl_we & ctrl_en & ctrl_start & ~busy_q & ~pending_q;
  assign ev_start = tick_rise & pending_q & en_q & ~wr_abort;
  assign ev_done  = tick_rise & busy_q & (cnt_q == last_cnt) & ~wr_abort;
  assign sh_hit   = tick_fall & busy_q & (cnt_q == sh_cnt) & ~wr_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      free_q    <= 1'b0;
      first_q   <= 1'b1;
      ext_q     <= 1'b0;
      busy_q    <= 1'b0;
      pending_q <= 1'b0;
      cnt_q     <= '0;
      sh_strobe <= 1'b0;
    end else begin
      sh_strobe <= sh_hit;
      if (ctrl_we) begin
        en_q   <= ctrl_en;
        free_q <= ctrl_free;
      end
      if (wr_abort) begin
        busy_q    <= 1'b0;
        pending_q <= 1'b0;
        cnt_q     <= '0;
        first_q   <= 1'b1;
      end else begin
        if (wr_go) pending_q <= 1'b1;
        if (ev_start) begin
          pending_q <= 1'b0;
          busy_q    <= 1'b1;
          cnt_q     <= CNT_W'(1);
          ext_q     <= first_q;
          first_q   <= 1'b0;
        end else if (ev_done) begin
          busy_q    <= 1'b0;
          cnt_q     <= '0;
          pending_q <= free_q;
        end else if (tick_rise && busy_q) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_rise,
  input  logic             busy_q,
  input  logic             ev_done,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_shadow,
  output logic [SEL_W-1:0] sel_active
);

  logic track_now;

  // Active copy follows the shadow when idle or in the completion cycle.
  assign track_now = tick_rise & (~busy_q | ev_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_shadow <= '0;
      sel_active <= '0;
    end else begin
      if (sel_we)    sel_shadow <= sel_wdata;
      if (track_now) sel_active <= sel_shadow;
    end
  end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_done,
  input  logic             clr_req,
  input  logic [RES_W-1:0] conv_value,
  output logic             done_flag,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);

  logic [15:0] wide;
  logic [15:0] pair;

  assign wide = 16'(conv_value);
  assign pair = split_bytes(wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
    end else begin
      if (ev_done) begin
        done_flag <= 1'b1;
        res_hi    <= pair[15:8];
        res_lo    <= pair[7:0];
      end else if (clr_req) begin
        done_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned CH_W     = 4,
  parameter int unsigned REF_W    = 2,
  parameter int unsigned RES_W    = 10,
  parameter int unsigned NORM_CYC = 13,
  parameter int unsigned EXT_CYC  = 25,
  parameter int unsigned SH_NORM  = 2,
  parameter int unsigned SH_EXT   = 14,
  parameter int unsigned SEL_W    = CH_W + REF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic             ctrl_start,
  input  logic             ctrl_free,
  input  logic             ctrl_clr,
  input  logic [RES_W-1:0] conv_value,
  output logic [SEL_W-1:0] sel_shadow,
  output logic [SEL_W-1:0] sel_active,
  output logic             sh_strobe,
  output logic             busy,
  output logic             start_pend,
  output logic             done_flag,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);

  localparam int unsigned CNT_W = $clog2(EXT_CYC + 1);

  logic busy_q;
  logic pending_q;
  logic ev_start;
  logic ev_done;
  logic clr_req;

  assign clr_req    = ctrl_we & ctrl_clr;
  assign busy       = busy_q;
  assign start_pend = busy_q | pending_q;

  adc_conv_timer #(
    .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC),
    .SH_NORM(SH_NORM), .SH_EXT(SH_EXT), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .tick_fall(tick_fall),
    .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_start(ctrl_start),
    .ctrl_free(ctrl_free), .busy_q(busy_q), .pending_q(pending_q),
    .ev_start(ev_start), .ev_done(ev_done), .sh_strobe(sh_strobe)
  );

  adc_sel_shadow #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .busy_q(busy_q),
    .ev_done(ev_done), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sel_shadow(sel_shadow), .sel_active(sel_active)
  );

  adc_result_latch #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .clr_req(clr_req),
    .conv_value(conv_value), .done_flag(done_flag),
    .res_hi(res_hi), .res_lo(res_lo)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned SEL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_rise,
  input logic             busy,
  input logic             done_flag,
  input logic             sh_strobe,
  input logic [SEL_W-1:0] sel_shadow,
  input logic [SEL_W-1:0] sel_active
);

  // R3
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_active));

  // R4
  sel_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (sel_active == $past(sel_shadow)));

  // R5
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_rise));

  // R7
  sh_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> $past(busy));

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .busy(busy),
  .done_flag(done_flag), .sh_strobe(sh_strobe),
  .sel_shadow(sel_shadow), .sel_active(sel_active)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_rise = 1'b0;
  logic       tick_fall = 1'b0;
  logic       sel_we = 1'b0;
  logic [5:0] sel_wdata = '0;
  logic       ctrl_we = 1'b0;
  logic       ctrl_en = 1'b0;
  logic       ctrl_start = 1'b0;
  logic       ctrl_free = 1'b0;
  logic       ctrl_clr = 1'b0;
  logic [9:0] conv_value = '0;
  logic [5:0] sel_shadow;
  logic [5:0] sel_active;
  logic       sh_strobe;
  logic       busy;
  logic       start_pend;
  logic       done_flag;
  logic [7:0] res_hi;
  logic [7:0] res_lo;

  int total = 0;
  int bad = 0;
  logic en_s = 1'b0;
  logic free_s = 1'b0;
  int meas_len;
  int meas_sh;
  logic frozen_ok;

  always #2.5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  // Converter clock: four system clocks per period.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick_rise = (ph == 0);
      tick_fall = (ph == 2);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic en, input logic st, input logic fr, input logic clr);
    @(negedge clk);
    ctrl_we = 1; ctrl_en = en; ctrl_start = st; ctrl_free = fr; ctrl_clr = clr;
    en_s = en; free_s = fr;
    @(negedge clk);
    ctrl_we = 0; ctrl_start = 0; ctrl_clr = 0;
  endtask

  task automatic sel_write(input logic [5:0] v);
    @(negedge clk);
    sel_we = 1; sel_wdata = v;
    @(negedge clk);
    sel_we = 0;
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick_rise) @(posedge clk);
    end
    #1;
  endtask

  // Counts rising ticks until done_flag; records the tick count at the strobe.
  task automatic measure(input logic [5:0] hold_sel);
    meas_len = 0; meas_sh = 0; frozen_ok = 1;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      if (tick_rise) meas_len++;
      #1;
      if (sh_strobe && meas_sh == 0) meas_sh = meas_len;
      if (done_flag) return;
      if (busy && sel_active != hold_sel) frozen_ok = 0;
    end
    meas_len = -1;
  endtask

  task automatic t_reset;
    check("R5 reset busy", busy, 0);
    check("R5 reset start_pend", start_pend, 0);
    check("R8 reset done_flag", done_flag, 0);
    check("R9 reset res", {res_hi, res_lo}, 0);
    check("R2 reset sel_active", sel_active, 0);
  endtask

  task automatic t_idle_sel;
    sel_write(6'h25);
    check("R1 shadow readback", sel_shadow, 6'h25);
    wait_rises(2);
    check("R2 active tracks idle", sel_active, 6'h25);
  endtask

  task automatic t_first_conv;
    conv_value = 10'h2C7;
    ctrl_write(1, 1, 0, 0);
    check("R5 start_pend after write", start_pend, 1);
    check("R5 busy before rise", busy, 0);
    fork
      begin
        wait_rises(3);
        sel_write(6'h3A);
        check("R1 shadow write while busy", sel_shadow, 6'h3A);
      end
      measure(6'h25);
    join
    check("R6 extended length", meas_len, 25);
    check("R7 extended strobe cycle", meas_sh, 14);
    check("R3 active frozen", frozen_ok, 1);
    check("R4 active reload at completion", sel_active, 6'h3A);
    check("R9 result high", res_hi, 8'h02);
    check("R9 result low", res_lo, 8'hC7);
    check("R5 busy clear at completion", busy, 0);
    check("R5 start_pend clear", start_pend, 0);
  endtask

  task automatic t_clear_and_normal;
    ctrl_write(1, 0, 0, 1);
    check("R8 flag cleared", done_flag, 0);
    conv_value = 10'h155;
    ctrl_write(1, 1, 0, 0);
    fork
      begin
        wait_rises(4);
        ctrl_write(1, 1, 0, 0);   // R11 start while busy ignored
      end
      measure(6'h3A);
    join
    check("R6 normal length", meas_len, 13);
    check("R7 normal strobe cycle", meas_sh, 2);
    check("R9 result high 2", res_hi, 8'h01);
    check("R9 result low 2", res_lo, 8'h55);
    wait_rises(20);
    check("R11 no extra conversion", busy | start_pend, 0);
  endtask

  task automatic t_disabled_start;
    ctrl_write(1, 0, 0, 1);
    ctrl_write(0, 1, 0, 0);
    check("R11 start with enable off", start_pend, 0);
    wait_rises(4);
    check("R11 no conversion when disabled", busy, 0);
  endtask

  task automatic t_free_run;
    ctrl_write(1, 1, 1, 0);
    measure(sel_active);
    check("R12 extended after re-enable", meas_len, 25);
    ctrl_write(1, 0, 1, 1);
    conv_value = 10'h0AA;
    measure(sel_active);
    check("R10 chained conversion length", meas_len, 13);
    check("R10 chained result low", res_lo, 8'hAA);
    ctrl_write(1, 0, 0, 1);
    measure(sel_active);
    check("R10 last chained conversion", meas_len, 13);
    wait_rises(20);
    check("R10 chain stops", busy, 0);
  endtask

  task automatic t_abort;
    ctrl_write(1, 0, 0, 1);
    ctrl_write(1, 1, 0, 0);
    wait_rises(5);
    ctrl_write(0, 0, 0, 0);
    check("R12 abort busy", busy, 0);
    check("R12 abort start_pend", start_pend, 0);
    wait_rises(30);
    check("R12 abort no flag", done_flag, 0);
    ctrl_write(1, 1, 0, 0);
    measure(sel_active);
    check("R12 extended after abort", meas_len, 25);
    check("R8 flag set", done_flag, 1);
  endtask

  initial begin
    #(2_000_000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_sel();
    t_first_conv();
    t_clear_and_normal();
    t_disabled_start();
    t_free_run();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule